// File: doc/BRIEF.md
# Programmable static memory cycle timer

This block times one bus cycle at a time for two static (non-DRAM) memory regions. A requester raises a request strobe together with a region select and a read/write flag. Timing fields taken from a control word come in at the same time. The block then runs an optional address setup phase, an access phase and an optional hold phase. It drives a chip-select line for the selected region, an output-enable or write-enable strobe, a busy flag and a one-cycle done pulse.

The two regions do not offer the same timing controls. Region 0 is the wide region. It has a 3-bit access field and a 1-bit setup field. Region 1 is the narrow region. It has a 2-bit access field and a hold field whose width is a parameter. With a 2-bit hold field, region 1 can stretch its hold phase to as many as three cycles. All fields are captured at the moment a request is accepted.

Top module: `smc_cycle_timer`

## Requirements
- R1: For region 0 the access phase lasts `a_access_i + 1` cycles, so a 3-bit field gives 1 to 8 cycles.
- R2: For region 0, `a_setup_i = 1` inserts one setup cycle before the access phase. During setup, chip-select is high and both strobes are low. Region 1 never has a setup phase.
- R3: For region 1 the access phase lasts `b_access_i + 1` cycles, so a 2-bit field gives 1 to 4 cycles.
- R4: For region 1 the hold phase lasts `b_hold_i` cycles, with the field value used directly as the count. During hold, chip-select is high and both strobes are low. Region 0 never has a hold phase.
- R5: `cs_o[0]` serves region 0 (`region_i = 0`) and `cs_o[1]` serves region 1. Only the selected line is asserted. It stays high without a gap from the first setup cycle through the last hold cycle.
- R6: During the access phase, `oe_o` is high for a read (`write_i = 0`) and `we_o` is high for a write (`write_i = 1`). Outside the access phase both strobes are low, and they are never high together.
- R7: A setup or hold count of zero removes that phase. With no setup, the access phase starts in the first cycle after acceptance.
- R8: A request is accepted only in a cycle where `busy_o` is low. A request raised while `busy_o` is high starts no bus cycle and does not change the cycle in progress.
- R9: `busy_o` is high from the cycle after acceptance through the last cycle of the bus cycle. `done_o` is high for exactly one cycle, and that cycle is the last one.
- R10: The timing fields, region select and read/write flag are sampled at acceptance. Changing them during a bus cycle does not affect that cycle.
- R11: After reset, `cs_o`, `oe_o`, `we_o`, `busy_o` and `done_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe |
| region_i | input | 1 | Region select: 0 wide, 1 narrow |
| write_i | input | 1 | 1 = write, 0 = read |
| a_access_i | input | A_ACC_W | Region 0 access field (count minus one) |
| a_setup_i | input | 1 | Region 0 setup enable |
| b_access_i | input | B_ACC_W | Region 1 access field (count minus one) |
| b_hold_i | input | B_HOLD_W | Region 1 hold count |
| cs_o | output | 2 | Chip-select per region, active high |
| oe_o | output | 1 | Output-enable strobe |
| we_o | output | 1 | Write-enable strobe |
| busy_o | output | 1 | Bus cycle in progress |
| done_o | output | 1 | Last cycle of the bus cycle |

## Verification
The bench builds the block with `B_HOLD_W = 2` and keeps the default widths for the two access fields. This makes region 1 hold counts of 0 to 3 reachable, so the direct hold encoding is exercised beyond the single-bit case. The bench sweeps every region 0 access value from 1 to 8 with setup turned on and off, and every region 1 access and hold combination.

// File: rtl/smc_pkg.sv
package smc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACCESS = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    localparam int SMC_REGIONS = 2;

endpackage

// File: rtl/smc_timing_sel.sv
module smc_timing_sel #(
    parameter int A_ACC_W  = 3,
    parameter int B_ACC_W  = 2,
    parameter int B_HOLD_W = 1,
    parameter int CNT_W    = 4
) (
    input  logic                region_i,
    input  logic [A_ACC_W-1:0]  a_access_i,
    input  logic                a_setup_i,
    input  logic [B_ACC_W-1:0]  b_access_i,
    input  logic [B_HOLD_W-1:0] b_hold_i,
    output logic [CNT_W-1:0]    setup_len_o,
    output logic [CNT_W-1:0]    access_len_o,
    output logic [CNT_W-1:0]    hold_len_o
);

    // Turn the selected region's fields into phase lengths in cycles.
    always_comb begin
        if (region_i) begin
            setup_len_o  = '0;
            access_len_o = CNT_W'(b_access_i) + CNT_W'(1);
            hold_len_o   = CNT_W'(b_hold_i);
        end else begin
            setup_len_o  = CNT_W'(a_setup_i);
            access_len_o = CNT_W'(a_access_i) + CNT_W'(1);
            hold_len_o   = '0;
        end
    end

endmodule

// File: rtl/smc_phase_seq.sv
module smc_phase_seq
    import smc_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] setup_len_i,
    input  logic [CNT_W-1:0] access_len_i,
    input  logic [CNT_W-1:0] hold_len_i,
    output phase_e           phase_o,
    output logic             last_o
);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] acc;
        logic [CNT_W-1:0] hold;
    } seq_t;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.acc  = access_len_i;
                    st_d.hold = hold_len_i;
                    if (setup_len_i != '0) begin
                        st_d.phase = PH_SETUP;
                        st_d.cnt   = setup_len_i - ONE;
                    end else begin
                        st_d.phase = PH_ACCESS;
                        st_d.cnt   = access_len_i - ONE;
                    end
                end
            end
            PH_SETUP: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_ACCESS;
                    st_d.cnt   = st_q.acc - ONE;
                end else begin
                    st_d.cnt = st_q.cnt - ONE;
                end
            end
            PH_ACCESS: begin
                if (st_q.cnt == '0) begin
                    if (st_q.hold != '0) begin
                        st_d.phase = PH_HOLD;
                        st_d.cnt   = st_q.hold - ONE;
                    end else begin
                        st_d.phase = PH_IDLE;
                    end
                end else begin
                    st_d.cnt = st_q.cnt - ONE;
                end
            end
            PH_HOLD: begin
                if (st_q.cnt == '0) st_d.phase = PH_IDLE;
                else                st_d.cnt   = st_q.cnt - ONE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, acc: '0, hold: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;
    assign last_o  = (st_q.cnt == '0) &&
                     ((st_q.phase == PH_HOLD) ||
                      (st_q.phase == PH_ACCESS && st_q.hold == '0));

    // R2: the final setup cycle hands over to access
    assert_setup_to_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_SETUP && st_q.cnt == '0) |=> (st_q.phase == PH_ACCESS));

    // R7: zero setup goes straight to access
    assert_zero_setup_skip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_IDLE && start_i && setup_len_i == '0) |=> (st_q.phase == PH_ACCESS));

    // R9: the last cycle is followed by idle
    assert_last_then_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> (st_q.phase == PH_IDLE));

endmodule

// File: rtl/smc_cycle_timer.sv
module smc_cycle_timer
    import smc_pkg::*;
#(
    parameter int A_ACC_W  = 3,
    parameter int B_ACC_W  = 2,
    parameter int B_HOLD_W = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_i,
    input  logic                          region_i,
    input  logic                          write_i,
    input  logic [A_ACC_W-1:0]            a_access_i,
    input  logic                          a_setup_i,
    input  logic [B_ACC_W-1:0]            b_access_i,
    input  logic [B_HOLD_W-1:0]           b_hold_i,
    output logic [SMC_REGIONS-1:0]        cs_o,
    output logic                          oe_o,
    output logic                          we_o,
    output logic                          busy_o,
    output logic                          done_o
);

    localparam int MAX_AB = (A_ACC_W > B_ACC_W) ? A_ACC_W : B_ACC_W;
    localparam int MAX_W  = (MAX_AB > B_HOLD_W) ? MAX_AB : B_HOLD_W;
    localparam int CNT_W  = MAX_W + 1;

    typedef struct packed {
        logic region;
        logic write;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic             accept;
    logic [CNT_W-1:0] setup_len, access_len, hold_len;
    phase_e           phase;
    logic             last;

    smc_timing_sel #(
        .A_ACC_W (A_ACC_W),
        .B_ACC_W (B_ACC_W),
        .B_HOLD_W(B_HOLD_W),
        .CNT_W   (CNT_W)
    ) u_sel (
        .region_i    (region_i),
        .a_access_i  (a_access_i),
        .a_setup_i   (a_setup_i),
        .b_access_i  (b_access_i),
        .b_hold_i    (b_hold_i),
        .setup_len_o (setup_len),
        .access_len_o(access_len),
        .hold_len_o  (hold_len)
    );

    smc_phase_seq #(
        .CNT_W(CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (accept),
        .setup_len_i (setup_len),
        .access_len_i(access_len),
        .hold_len_i  (hold_len),
        .phase_o     (phase),
        .last_o      (last)
    );

    assign accept = req_i && (phase == PH_IDLE);

    always_comb begin
        ctl_d = ctl_q;
        if (accept) begin
            ctl_d.region = region_i;
            ctl_d.write  = write_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign busy_o = (phase != PH_IDLE);
    assign done_o = last;
    assign oe_o   = (phase == PH_ACCESS) && !ctl_q.write;
    assign we_o   = (phase == PH_ACCESS) &&  ctl_q.write;

    for (genvar g = 0; g < SMC_REGIONS; g++) begin : g_cs
        assign cs_o[g] = busy_o && (ctl_q.region == 1'(g));
    end

    assert_single_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_o));

    assert_cs_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> $stable(cs_o));

    assert_strobe_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(oe_o && we_o));

    assert_strobe_inside_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_o || we_o) |-> (cs_o != '0));

    assert_accept_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !busy_o) |=> busy_o);

    assert_done_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

endmodule

// File: tb/smc_cycle_timer_bench.sv
module smc_cycle_timer_bench;

    localparam int A_ACC_W  = 3;
    localparam int B_ACC_W  = 2;
    localparam int B_HOLD_W = 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                req_i = 1'b0;
    logic                region_i = 1'b0;
    logic                write_i = 1'b0;
    logic [A_ACC_W-1:0]  a_access_i = '0;
    logic                a_setup_i = 1'b0;
    logic [B_ACC_W-1:0]  b_access_i = '0;
    logic [B_HOLD_W-1:0] b_hold_i = '0;
    logic [1:0]          cs_o;
    logic                oe_o, we_o, busy_o, done_o;

    always #4 clk = ~clk;

    smc_cycle_timer #(
        .A_ACC_W (A_ACC_W),
        .B_ACC_W (B_ACC_W),
        .B_HOLD_W(B_HOLD_W)
    ) u_smc_cycle_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .region_i  (region_i),
        .write_i   (write_i),
        .a_access_i(a_access_i),
        .a_setup_i (a_setup_i),
        .b_access_i(b_access_i),
        .b_hold_i  (b_hold_i),
        .cs_o      (cs_o),
        .oe_o      (oe_o),
        .we_o      (we_o),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );

    typedef struct {
        bit rg;
        bit wr;
        int st;
        int ac;
        int hd;
    } item_t;

    item_t q[$];
    int    n_checks = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;
    bit    monitor_on = 1'b0;

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // Driver: waits for idle, presents one request, pushes the expected item,
    // then scrambles every field while the cycle runs (R10).
    task automatic issue(input bit rg, input bit wr, input int st, input int ac, input int hd);
        item_t it;
        @(negedge clk);
        while (busy_o) @(negedge clk);
        region_i = rg;
        write_i  = wr;
        if (rg == 1'b0) begin
            a_access_i = A_ACC_W'(ac - 1);
            a_setup_i  = st[0];
            b_access_i = '1;
            b_hold_i   = '1;
        end else begin
            b_access_i = B_ACC_W'(ac - 1);
            b_hold_i   = B_HOLD_W'(hd);
            a_access_i = '1;
            a_setup_i  = 1'b1;
        end
        req_i = 1'b1;
        it = '{rg: rg, wr: wr, st: st, ac: ac, hd: hd};
        q.push_back(it);
        @(negedge clk);
        req_i      = 1'b0;
        region_i   = ~region_i;
        write_i    = ~write_i;
        a_access_i = ~a_access_i;
        a_setup_i  = ~a_setup_i;
        b_access_i = ~b_access_i;
        b_hold_i   = ~b_hold_i;
    endtask

    // Monitor: measures each bus cycle at the ports and compares with the queue.
    int   m_n, m_s, m_a, m_h, m_d, m_dpos;
    bit   m_in = 1'b0, m_wr, m_rg, m_bad_cs;
    logic [1:0] m_cs;

    always @(negedge clk) begin
        if (rst_n && monitor_on) begin
            check(busy_o == (cs_o != 2'b00), "R9", "busy matches chip-select", int'(busy_o), int'(cs_o != 2'b00));
            check(!(oe_o && we_o), "R6", "strobes exclusive", int'({oe_o, we_o}), 0);
            if (cs_o != 2'b00) begin
                if (!m_in) begin
                    m_in = 1'b1; m_n = 0; m_s = 0; m_a = 0; m_h = 0; m_d = 0; m_dpos = 0;
                    m_cs = cs_o; m_rg = cs_o[1]; m_wr = 1'b0; m_bad_cs = (cs_o == 2'b11);
                end
                if (cs_o != m_cs) m_bad_cs = 1'b1;
                m_n++;
                if (oe_o || we_o) begin
                    m_a++;
                    if (we_o) m_wr = 1'b1;
                end else if (m_a == 0) begin
                    m_s++;
                end else begin
                    m_h++;
                end
                if (done_o) begin
                    m_d++;
                    m_dpos = m_n;
                end
            end else begin
                check(!done_o, "R9", "done outside a bus cycle", int'(done_o), 0);
                if (m_in) begin
                    item_t it;
                    m_in = 1'b0;
                    if (q.size() == 0) begin
                        check(1'b0, "R8", "bus cycle with no accepted request", 1, 0);
                    end else begin
                        it = q.pop_front();
                        check(m_rg == it.rg, "R5", "selected chip-select line", int'(m_rg), int'(it.rg));
                        check(!m_bad_cs, "R5", "chip-select steady and single", int'(m_bad_cs), 0);
                        check(m_wr == it.wr, "R6", "strobe type", int'(m_wr), int'(it.wr));
                        check(m_s == it.st, "R2/R7", "setup cycles", m_s, it.st);
                        check(m_a == it.ac, it.rg ? "R3/R10" : "R1/R10", "access cycles", m_a, it.ac);
                        check(m_h == it.hd, "R4/R7", "hold cycles", m_h, it.hd);
                        check(m_d == 1 && m_dpos == m_n, "R9", "done position", m_dpos, m_n);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "WDOG", "run did not complete", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check(cs_o == 2'b00 && !oe_o && !we_o && !busy_o && !done_o, "R11", "outputs in reset",
              int'({cs_o, oe_o, we_o, busy_o, done_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_o == 2'b00 && !busy_o && !done_o, "R11", "outputs after reset release",
              int'({cs_o, busy_o, done_o}), 0);
        monitor_on = 1'b1;

        // R1, R2, R7: wide region, every access length, setup on and off
        for (int ac = 1; ac <= 8; ac++) begin
            issue(1'b0, ac[0], 0, ac, 0);
            issue(1'b0, ~ac[0], 1, ac, 0);
        end

        // R3, R4, R7: narrow region, every access and hold combination
        for (int ac = 1; ac <= 4; ac++) begin
            for (int hd = 0; hd <= 3; hd++) begin
                issue(1'b1, hd[0], 0, ac, hd);
            end
        end

        // R8: requests raised while busy are ignored
        issue(1'b0, 1'b0, 1, 8, 0);
        region_i = 1'b1;
        b_access_i = '0;
        b_hold_i = '0;
        req_i = 1'b1;
        repeat (4) @(negedge clk);
        req_i = 1'b0;
        while (busy_o) @(negedge clk);
        repeat (3) @(negedge clk);
        check(!busy_o && cs_o == 2'b00, "R8", "no cycle from a request made while busy",
              int'({busy_o, cs_o}), 0);

        // Back-to-back traffic on alternating regions
        issue(1'b1, 1'b1, 0, 1, 0);
        issue(1'b0, 1'b1, 0, 1, 0);
        issue(1'b1, 1'b0, 0, 4, 3);

        while (busy_o) @(negedge clk);
        repeat (4) @(negedge clk);
        check(q.size() == 0, "R8", "every accepted request produced a cycle", q.size(), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule